// File: doc/BRIEF.md
# Floating-Point Exception Status Logic

This block keeps the exception bookkeeping of a floating-point status register. Each time the floating-point datapath finishes an operation it pulses a completion strobe together with a 5-bit exception vector. The block records that vector as the current-exception field and checks it against a 5-bit trap-enable mask. It then either raises a one-cycle trap request or folds the exceptions into a sticky accrued field.

The block also holds a rounding-direction code and a flag showing that an external deferred-trap queue is holding entries. Supervisor software reaches the writable fields through a single write port whose bit positions match the status word. Arithmetic, rounding and the queue itself sit outside the block. The status word is assembled only from registers, so it is stable for a full cycle.

Top module: `fpx_status`

## Requirements
- R1: In the cycle after a cycle with `rst` high, `status_word` is all zeros and `trap_req` is 0.
- R2: After a cycle with `op_done` high and `wr_en` low, the current field (`status_word[4:0]`) holds that operation's screened exceptions, and any kind that did not occur reads 0. The bit order is 4 invalid, 3 overflow, 2 underflow, 1 divide-by-zero, 0 inexact.
- R3: When `op_exc` reports invalid and divide-by-zero together, the divide-by-zero bit is dropped before recording, accrual and the trap decision.
- R4: `trap_req` is 1 in the cycle after `op_done` exactly when the screened exceptions AND the mask (`status_word[14:10]`, same bit order) are nonzero. Otherwise it is 0.
- R5: When an operation completes without a trap and without a write, the accrued field (`status_word[9:5]`) becomes its old value OR the screened exceptions.
- R6: When an operation completes and raises a trap, the accrued field keeps its old value.
- R7: In a cycle with neither `op_done` nor `wr_en`, the current, accrued, mask and rounding fields keep their values and `trap_req` is 0 in the next cycle.
- R8: A write loads current, accrued, mask and rounding direction (`status_word[16:15]`) from the same bit positions of `wr_data`. Bits above 17 always read 0.
- R9: A write in the same cycle as `op_done` takes priority for all written fields. The trap decision for that operation uses the mask in effect before the write.
- R10: `status_word[17]` equals `q_nonempty` from the previous cycle (0 means the queue is empty), and no write changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | A floating-point operation completed this cycle |
| op_exc | input | 5 | Exceptions raised by that operation |
| wr_en | input | 1 | Write the writable status fields |
| wr_data | input | 17 | Write data, aligned with status_word[16:0] |
| q_nonempty | input | 1 | Deferred queue holds entries |
| trap_req | output | 1 | Floating-point exception trap request, one cycle |
| status_word | output | 32 | Assembled status register |

## Verification
The bench drives invalid and divide-by-zero together. A design that skipped the screening would report divide-by-zero, and with only that kind enabled it would also raise a spurious trap. It then raises exceptions that hit an enabled mask bit and confirms the accrued field stays frozen; an implementation that always accrued would set the trapped bit. A write collides with a completing operation to show that the written values win while the trap still follows the old mask. A design that let the operation win, or that used the new mask, would show a wrong word or a wrong trap. Seeded random traffic mixes idle cycles, writes and queue-flag toggles against a bench model.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W    = 5;
  localparam int X_INV    = 4;
  localparam int X_OVF    = 3;
  localparam int X_UNF    = 2;
  localparam int X_DZ     = 1;
  localparam int X_NX     = 0;
  localparam int CUR_LSB  = 0;
  localparam int ACC_LSB  = EXC_W;
  localparam int MASK_LSB = 2 * EXC_W;
  localparam int RM_LSB   = 3 * EXC_W;
  typedef logic [EXC_W-1:0] exc_t;
endpackage

// File: rtl/fpx_exc_screen.sv
module fpx_exc_screen
  import fpx_pkg::*;
(
  input  logic op_done,
  input  exc_t raw,
  input  exc_t mask,
  output exc_t clean,
  output logic trap_now
);
  // Divide-by-zero is not reported when the same operation is invalid (0/0).
  for (genvar g = 0; g < EXC_W; g++) begin : g_bit
    if (g == X_DZ) begin : g_dz
      assign clean[g] = raw[g] & ~raw[X_INV];
    end else begin : g_pass
      assign clean[g] = raw[g];
    end
  end

  assign trap_now = op_done & (|(clean & mask));
endmodule

// File: rtl/fpx_exc_fields.sv
module fpx_exc_fields
  import fpx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic op_done,
  input  exc_t clean,
  input  logic trap_now,
  input  logic wr_en,
  input  exc_t wr_cur,
  input  exc_t wr_acc,
  output exc_t cur,
  output exc_t acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= '0;
      acc <= '0;
    end else if (wr_en) begin
      cur <= wr_cur;
      acc <= wr_acc;
    end else if (op_done) begin
      cur <= clean;
      if (!trap_now) acc <= acc | clean;
    end
  end

  p_cur_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!op_done && !wr_en) |=> $stable(cur));
  p_acc_grow_r5: assert property (@(posedge clk) disable iff (rst)
    (op_done && !trap_now && !wr_en) |=> ((acc & $past(acc)) == $past(acc)));
  p_acc_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (op_done && trap_now && !wr_en) |=> $stable(acc));
  p_no_dz_inv_r3: assert property (@(posedge clk) disable iff (rst)
    $past(op_done && !wr_en && !rst) |-> !(cur[X_INV] && cur[X_DZ]));
endmodule

// File: rtl/fpx_ctrl_fields.sv
module fpx_ctrl_fields
  import fpx_pkg::*;
#(
  parameter int RM_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  exc_t            wr_mask,
  input  logic [RM_W-1:0] wr_rm,
  input  logic            q_nonempty,
  output exc_t            mask,
  output logic [RM_W-1:0] rm,
  output logic            qne
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      rm   <= '0;
      qne  <= 1'b0;
    end else begin
      qne <= q_nonempty;
      if (wr_en) begin
        mask <= wr_mask;
        rm   <= wr_rm;
      end
    end
  end

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(mask) && $stable(rm)));
  p_qne_track_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (qne == $past(q_nonempty)));
endmodule

// File: rtl/fpx_status.sv
module fpx_status
  import fpx_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int RM_W     = 2,
  localparam int WR_W    = RM_LSB + RM_W,
  localparam int QNE_POS = WR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_done,
  input  logic [EXC_W-1:0]    op_exc,
  input  logic                wr_en,
  input  logic [WR_W-1:0]     wr_data,
  input  logic                q_nonempty,
  output logic                trap_req,
  output logic [STATUS_W-1:0] status_word
);
  exc_t            clean, cur, acc, mask;
  logic            trap_now, qne;
  logic [RM_W-1:0] rm;

  fpx_exc_screen u_screen (
    .op_done (op_done),
    .raw     (op_exc),
    .mask    (mask),
    .clean   (clean),
    .trap_now(trap_now)
  );

  fpx_exc_fields u_exc (
    .clk     (clk),
    .rst     (rst),
    .op_done (op_done),
    .clean   (clean),
    .trap_now(trap_now),
    .wr_en   (wr_en),
    .wr_cur  (wr_data[CUR_LSB +: EXC_W]),
    .wr_acc  (wr_data[ACC_LSB +: EXC_W]),
    .cur     (cur),
    .acc     (acc)
  );

  fpx_ctrl_fields #(.RM_W(RM_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_mask   (wr_data[MASK_LSB +: EXC_W]),
    .wr_rm     (wr_data[RM_LSB +: RM_W]),
    .q_nonempty(q_nonempty),
    .mask      (mask),
    .rm        (rm),
    .qne       (qne)
  );

  always_ff @(posedge clk) begin
    if (rst) trap_req <= 1'b0;
    else     trap_req <= trap_now;
  end

  always_comb begin
    status_word                        = '0;
    status_word[CUR_LSB +: EXC_W]      = cur;
    status_word[ACC_LSB +: EXC_W]      = acc;
    status_word[MASK_LSB +: EXC_W]     = mask;
    status_word[RM_LSB +: RM_W]        = rm;
    status_word[QNE_POS]               = qne;
  end

  p_trap_needs_op_r4: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(op_done));
  p_trap_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (op_done && ((op_exc & mask) == '0)) |=> !trap_req);
  p_idle_no_trap_r7: assert property (@(posedge clk) disable iff (rst)
    !op_done |=> !trap_req);
endmodule

// File: tb/test_fpx_status.sv
`timescale 1ns/1ps
module test_fpx_status;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_done, wr_en, q_nonempty;
  logic [4:0]  op_exc;
  logic [16:0] wr_data;
  logic        trap_req;
  logic [31:0] status_word;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_cur, m_acc, m_mask;
  logic [1:0] m_rm;
  logic       m_qne, m_trap;

  always #2.5 clk = ~clk;

  fpx_status i_fpx_status (
    .clk(clk), .rst(rst), .op_done(op_done), .op_exc(op_exc),
    .wr_en(wr_en), .wr_data(wr_data), .q_nonempty(q_nonempty),
    .trap_req(trap_req), .status_word(status_word)
  );

  function automatic logic [4:0] screen(input logic [4:0] e);
    logic [4:0] r = e;
    if (e[4]) r[1] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] model_word();
    return {14'b0, m_qne, m_rm, m_mask, m_acc, m_cur};
  endfunction

  task automatic check(input string tag);
    checks++;
    if (status_word !== model_word() || trap_req !== m_trap) begin
      errors++;
      $display("FAIL %s: word %h trap %b, expected word %h trap %b",
               tag, status_word, trap_req, model_word(), m_trap);
    end
  endtask

  task automatic step(input logic op, input logic [4:0] e, input logic wr,
                      input logic [16:0] wd, input logic qin, input string tag);
    logic [4:0] ec;
    logic       tn;
    @(negedge clk);
    op_done = op; op_exc = e; wr_en = wr; wr_data = wd; q_nonempty = qin;
    ec = screen(e);
    tn = op && ((ec & m_mask) != 5'd0);
    @(posedge clk);
    #1;
    if (op) begin
      m_cur = ec;
      if (!tn) m_acc = m_acc | ec;
    end
    if (wr) begin
      m_cur = wd[4:0]; m_acc = wd[9:5]; m_mask = wd[14:10]; m_rm = wd[16:15];
    end
    m_trap = tn;
    m_qne  = qin;
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R1 watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op_done = 0; op_exc = 0; wr_en = 0; wr_data = 0; q_nonempty = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; q_nonempty = 0;
    m_cur = 0; m_acc = 0; m_mask = 0; m_rm = 0; m_qne = 0; m_trap = 0;
    check("R1 reset");
    step(1, 5'b10101, 0, 17'd0, 0, "R2 R5 record and accrue");
    step(1, 5'b00000, 0, 17'd0, 0, "R2 clear current");
    step(0, 5'b00000, 1, {2'b10, 5'b00100, 5'b00000, 5'b00000}, 0, "R8 write mask");
    step(1, 5'b00110, 0, 17'd0, 0, "R4 R6 trap holds accrued");
    step(1, 5'b01000, 0, 17'd0, 0, "R4 R5 no trap accrues");
    step(1, 5'b10010, 0, 17'd0, 0, "R3 dz dropped with invalid");
    step(0, 5'b00000, 1, {2'b00, 5'b00010, 5'b00000, 5'b00000}, 0, "R8 mask dz only");
    step(1, 5'b10010, 0, 17'd0, 0, "R3 no dz trap on 0/0");
    step(1, 5'b00010, 0, 17'd0, 0, "R4 dz traps");
    step(0, 5'b11111, 0, 17'd0, 0, "R7 idle hold");
    step(0, 5'b00000, 1, 17'h1FFFF, 1, "R8 R10 all ones write");
    step(1, 5'b01000, 1, {2'b01, 5'b00000, 5'b00011, 5'b10000}, 1,
         "R9 write wins, old mask traps");
    step(1, 5'b01000, 0, 17'd0, 0, "R9 new mask in effect");
    step(0, 5'b00000, 1, 17'd0, 1, "R10 flag not writable");
    step(0, 5'b00000, 0, 17'd0, 0, "R10 flag follows input");
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 400; i++) begin
      logic op, wr, q;
      logic [4:0] e;
      logic [16:0] wd;
      op = ($urandom % 10) < 7;
      wr = ($urandom % 10) == 0;
      q  = $urandom % 2;
      e  = 5'($urandom);
      wd = 17'($urandom);
      step(op, e, wr, wd, q, "R2 R4 R5 R6 R9 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule